// File: doc/BRIEF.md
# Translation Protection Fault Checker

This block judges a single memory access against the translation entry that a TLB lookup has just produced. From the kind of access, the requester's privilege level, the hit flag, the entry's control fields and the interruption-collection enable, it picks the single most urgent fault. That fault, or "no fault", is reported one clock later as a 4-bit code with a one-cycle valid strobe. The TLB array, the page-table walker and the fault handlers are outside this block.

The block holds a small file of protection key registers. Each register has a valid bit, a key and three disable bits: read, write and execute. Software writes one register at a time through an index/data/write-enable port. A lookup compares the entry's key against every valid register. When more than one register matches, the one with the lowest index decides.

Access kinds on `req_kind` are: 0 instruction fetch, 1 load, 2 store, 3 semaphore, 4 speculative load. Values 5 to 7 are handled as a plain load. A read is needed by load, speculative load and semaphore. A write is needed by store and semaphore. Execute is needed by fetch. Privilege level 0 is the most privileged.

Top module: `prot_fault_chk`

## Requirements
- R1: `fault_valid` is high exactly in the cycle after a cycle with `req_valid` high, and carries that request's code. `fault_code` is 0 whenever `fault_valid` is low, including right after reset. Code 0 means no fault.
- R2: An access with `req_is32` high and a nonzero `req_addr_hi` reports code 11. This check outranks every other fault.
- R3: On a TLB miss (`tlb_hit` low) the code is as follows. A fetch reports 1. A data access with `ic_en` high reports 2. A data access with `ic_en` low reports 3 (nested miss).
- R4: A hit entry with the present bit low reports code 4.
- R5: A load, store or semaphore to an entry with `ent_natpage` high reports code 5. A speculative load or a fetch raises no fault for that attribute.
- R6: If no valid key register holds `ent_key`, the code is 6.
- R7: If the lowest-index matching key register disables a permission the access needs, the code is 7.
- R8: The code is 8 in either of two cases. The first is that `ent_rights` (bit 0 read allowed, bit 1 write allowed, bit 2 execute allowed) lacks a needed permission. The second is that `req_pl` is numerically greater than `ent_pl`.
- R9: An entry with the access bit low reports code 9.
- R10: A store or semaphore to an entry with the dirty bit low reports code 10. Loads, speculative loads and fetches ignore the dirty bit.
- R11: Only the highest-priority fault is reported. The order from highest to lowest is: 32-bit range, miss/nested, not present, NaT page, key miss, key permission, access rights, access bit, dirty bit.
- R12: Reset clears every key register's valid bit. A write through `pk_we` (with `pk_dis` bit 0 read, bit 1 write, bit 2 execute disable) takes effect for requests in later cycles. A request in the same cycle as the write sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access to check this cycle |
| req_kind | input | 3 | Access kind |
| req_pl | input | 2 | Requester privilege level |
| req_is32 | input | 1 | Access uses 32-bit addressing |
| req_addr_hi | input | 32 | Upper 32 bits of the virtual address |
| tlb_hit | input | 1 | Lookup found an entry |
| ic_en | input | 1 | Interruption collection enabled |
| ent_present | input | 1 | Entry present bit |
| ent_accessed | input | 1 | Entry access bit |
| ent_dirty | input | 1 | Entry dirty bit |
| ent_rights | input | 3 | Page rights: read, write, execute allowed |
| ent_pl | input | 2 | Entry privilege level |
| ent_natpage | input | 1 | Entry memory attribute is NaT page |
| ent_key | input | 24 | Entry protection key |
| pk_we | input | 1 | Key register write enable |
| pk_idx | input | 4 | Key register index |
| pk_valid | input | 1 | Valid bit to write |
| pk_key | input | 24 | Key to write |
| pk_dis | input | 3 | Read, write, execute disable bits to write |
| fault_valid | output | 1 | Result strobe, one cycle |
| fault_code | output | 4 | Reported fault, 0 for none |

## Verification
The assertions assume that the entry fields are meaningful only in a request cycle. They also assume that a result belongs to the request in the cycle just before it, so they tie each code to the inputs sampled one edge earlier. The stimulus sets every input at the falling edge and holds it through the next rising edge. It starts each case from a fault-free access and disturbs one or two fields, so each expected code follows directly from the priority list. Key writes happen between requests, except in one deliberate case where the write and a request share a cycle.

// File: rtl/prot_fault_chk.sv
module prot_fault_chk #(
  parameter int NUM_KEYS = 16,
  parameter int KEY_W    = 24,
  parameter int PL_W     = 2,
  parameter int HI_W     = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [2:0]                  req_kind,
  input  logic [PL_W-1:0]             req_pl,
  input  logic                        req_is32,
  input  logic [HI_W-1:0]             req_addr_hi,
  input  logic                        tlb_hit,
  input  logic                        ic_en,
  input  logic                        ent_present,
  input  logic                        ent_accessed,
  input  logic                        ent_dirty,
  input  logic [2:0]                  ent_rights,
  input  logic [PL_W-1:0]             ent_pl,
  input  logic                        ent_natpage,
  input  logic [KEY_W-1:0]            ent_key,
  input  logic                        pk_we,
  input  logic [$clog2(NUM_KEYS)-1:0] pk_idx,
  input  logic                        pk_valid,
  input  logic [KEY_W-1:0]            pk_key,
  input  logic [2:0]                  pk_dis,
  output logic                        fault_valid,
  output logic [3:0]                  fault_code
);

  localparam logic [3:0] C_NONE   = 4'd0;
  localparam logic [3:0] C_IMISS  = 4'd1;
  localparam logic [3:0] C_DMISS  = 4'd2;
  localparam logic [3:0] C_NEST   = 4'd3;
  localparam logic [3:0] C_NOTPR  = 4'd4;
  localparam logic [3:0] C_NAT    = 4'd5;
  localparam logic [3:0] C_KMISS  = 4'd6;
  localparam logic [3:0] C_KPERM  = 4'd7;
  localparam logic [3:0] C_RIGHTS = 4'd8;
  localparam logic [3:0] C_ABIT   = 4'd9;
  localparam logic [3:0] C_DBIT   = 4'd10;
  localparam logic [3:0] C_RANGE  = 4'd11;

  logic [KEY_W-1:0] kr_key [NUM_KEYS];
  logic [2:0]       kr_dis [NUM_KEYS];
  logic [NUM_KEYS-1:0] kr_vld;
  logic [NUM_KEYS-1:0] kr_hit;
  logic [2:0]       sel_dis;
  logic [3:0]       code_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kr_vld <= '0;
      for (int i = 0; i < NUM_KEYS; i++) begin
        kr_key[i] <= '0;
        kr_dis[i] <= '0;
      end
    end else if (pk_we) begin
      kr_vld[pk_idx] <= pk_valid;
      kr_key[pk_idx] <= pk_key;
      kr_dis[pk_idx] <= pk_dis;
    end
  end

  for (genvar g = 0; g < NUM_KEYS; g++) begin : g_match
    assign kr_hit[g] = kr_vld[g] && (kr_key[g] == ent_key);
  end

  always_comb begin
    sel_dis = '0;
    for (int i = NUM_KEYS - 1; i >= 0; i--)
      if (kr_hit[i]) sel_dis = kr_dis[i];
  end

  wire is_fetch = req_kind == 3'd0;
  wire is_store = req_kind == 3'd2;
  wire is_sema  = req_kind == 3'd3;
  wire is_spec  = req_kind == 3'd4;
  wire need_r   = !is_fetch && !is_store;
  wire need_w   = is_store || is_sema;
  wire need_x   = is_fetch;

  wire range_bad  = req_is32 && (|req_addr_hi);
  wire nat_bad    = ent_natpage && !is_fetch && !is_spec;
  wire key_found  = |kr_hit;
  wire kperm_bad  = (need_r && sel_dis[0]) || (need_w && sel_dis[1]) || (need_x && sel_dis[2]);
  wire rights_bad = (need_r && !ent_rights[0]) || (need_w && !ent_rights[1]) ||
                    (need_x && !ent_rights[2]) || (req_pl > ent_pl);
  wire dirty_bad  = need_w && !ent_dirty;

  always_comb begin
    if (range_bad)          code_d = C_RANGE;
    else if (!tlb_hit)      code_d = is_fetch ? C_IMISS : (ic_en ? C_DMISS : C_NEST);
    else if (!ent_present)  code_d = C_NOTPR;
    else if (nat_bad)       code_d = C_NAT;
    else if (!key_found)    code_d = C_KMISS;
    else if (kperm_bad)     code_d = C_KPERM;
    else if (rights_bad)    code_d = C_RIGHTS;
    else if (!ent_accessed) code_d = C_ABIT;
    else if (dirty_bad)     code_d = C_DBIT;
    else                    code_d = C_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_valid <= 1'b0;
      fault_code  <= C_NONE;
    end else begin
      fault_valid <= req_valid;
      fault_code  <= req_valid ? code_d : C_NONE;
    end
  end

  p_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> fault_valid);
  p_no_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !fault_valid);
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_valid |-> fault_code == C_NONE);
  p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is32 && req_addr_hi != '0) |=> fault_code == C_RANGE);
  p_nested_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is32 && !tlb_hit && req_kind != 3'd0 && !ic_en) |=> fault_code == C_NEST);
  p_notpres_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is32 && tlb_hit && !ent_present) |=> fault_code == C_NOTPR);
  p_nat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_code == C_NAT |-> $past(ent_natpage) && $past(req_kind) != 3'd4 && $past(req_kind) != 3'd0);
  p_dirty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_code == C_DBIT |-> !$past(ent_dirty) && ($past(req_kind) == 3'd2 || $past(req_kind) == 3'd3));

endmodule

// File: tb/test_prot_fault_chk.sv
module test_prot_fault_chk;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic req_valid = 0, req_is32 = 0, tlb_hit = 1, ic_en = 1;
  logic [2:0] req_kind = 1;
  logic [1:0] req_pl = 0, ent_pl = 3;
  logic [31:0] req_addr_hi = 0;
  logic ent_present = 1, ent_accessed = 1, ent_dirty = 1, ent_natpage = 0;
  logic [2:0] ent_rights = 3'b111;
  logic [23:0] ent_key = 24'h123456;
  logic pk_we = 0, pk_valid = 0;
  logic [3:0] pk_idx = 0;
  logic [23:0] pk_key = 0;
  logic [2:0] pk_dis = 0;
  logic fault_valid;
  logic [3:0] fault_code;

  prot_fault_chk i_prot_fault_chk (.*);

  int tests = 0, fails = 0;
  int exp_q[$];
  string tag_q[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clean(input logic [2:0] kind);
    req_kind = kind; req_pl = 0; req_is32 = 0; req_addr_hi = 0;
    tlb_hit = 1; ic_en = 1; ent_present = 1; ent_accessed = 1; ent_dirty = 1;
    ent_rights = 3'b111; ent_pl = 3; ent_natpage = 0; ent_key = 24'h123456;
  endtask

  task automatic fire(input int exp, input string tag);
    req_valid = 1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wkey(input int idx, input logic v, input logic [23:0] k, input logic [2:0] d);
    pk_we = 1; pk_idx = 4'(idx); pk_valid = v; pk_key = k; pk_dis = d;
    @(negedge clk);
    pk_we = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && fault_valid) begin
      if (exp_q.size() == 0) check(0, "R1 unexpected strobe", fault_code, -1);
      else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(fault_code == 4'(e), t, fault_code, e);
      end
    end
  end

  initial begin
    #1_000_000;
    check(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(fault_valid == 0 && fault_code == 0, "R1 reset state", fault_code, 0);
    rst_n = 1;
    @(negedge clk);
    // R12: reset leaves no valid key
    clean(1); fire(6, "R12 keys invalid after reset");
    wkey(0, 1, 24'h123456, 3'b000);
    wkey(5, 1, 24'hABCDEF, 3'b001);
    wkey(9, 0, 24'h000777, 3'b000);
    clean(1); fire(0, "R1 clean load");
    clean(2); fire(0, "R1 clean store");
    clean(0); fire(0, "R1 clean fetch");
    @(negedge clk);
    check(fault_valid == 0 && fault_code == 0, "R1 idle after results", fault_code, 0);
    // R2 / R11
    clean(1); req_is32 = 1; req_addr_hi = 1; tlb_hit = 0; fire(11, "R2 R11 range over miss");
    clean(2); req_is32 = 1; req_addr_hi = 32'h8000_0000; fire(11, "R2 high bit");
    clean(1); req_is32 = 1; fire(0, "R2 region zero ok");
    clean(1); req_addr_hi = 32'hFFFF; fire(0, "R2 64-bit access ignores check");
    // R3
    clean(0); tlb_hit = 0; ic_en = 0; fire(1, "R3 fetch miss");
    clean(1); tlb_hit = 0; fire(2, "R3 data miss");
    clean(2); tlb_hit = 0; ic_en = 0; fire(3, "R3 nested store");
    clean(4); tlb_hit = 0; ic_en = 0; ent_present = 0; fire(3, "R3 nested specload");
    // R4
    clean(1); ent_present = 0; ent_natpage = 1; fire(4, "R4 R11 not present over nat");
    // R5
    clean(1); ent_natpage = 1; fire(5, "R5 load nat");
    clean(4); ent_natpage = 1; fire(0, "R5 specload nat");
    clean(0); ent_natpage = 1; fire(0, "R5 fetch nat");
    clean(2); ent_natpage = 1; ent_key = 24'h999999; fire(5, "R5 R11 nat over key miss");
    // R6
    clean(1); ent_key = 24'h000777; fire(6, "R6 invalid register");
    clean(1); ent_key = 24'h999999; ent_rights = 0; fire(6, "R6 R11 no match over rights");
    // R7
    clean(1); ent_key = 24'hABCDEF; fire(7, "R7 read disabled");
    clean(2); ent_key = 24'hABCDEF; fire(0, "R7 store not disabled");
    clean(3); ent_key = 24'hABCDEF; ent_rights = 0; fire(7, "R7 R11 sema over rights");
    // R8
    clean(2); ent_rights = 3'b001; fire(8, "R8 store read-only page");
    clean(0); ent_rights = 3'b011; fire(8, "R8 fetch no exec");
    clean(1); req_pl = 3; ent_pl = 0; fire(8, "R8 privilege");
    clean(1); req_pl = 2; ent_pl = 2; ent_accessed = 0; fire(9, "R8 equal pl passes");
    // R9 / R10
    clean(2); ent_accessed = 0; ent_dirty = 0; fire(9, "R9 R11 access over dirty");
    clean(2); ent_dirty = 0; fire(10, "R10 store dirty");
    clean(3); ent_dirty = 0; fire(10, "R10 sema dirty");
    clean(1); ent_dirty = 0; fire(0, "R10 load ignores dirty");
    clean(4); ent_dirty = 0; fire(0, "R10 specload ignores dirty");
    // R12 rewrite and same-cycle write
    wkey(5, 1, 24'hABCDEF, 3'b000);
    clean(1); ent_key = 24'hABCDEF; fire(0, "R12 rewrite enables read");
    wkey(0, 0, 24'h123456, 3'b000);
    clean(1); fire(6, "R12 invalidated");
    pk_we = 1; pk_idx = 0; pk_valid = 1; pk_key = 24'h123456; pk_dis = 0;
    clean(1); fire(6, "R12 same cycle sees old");
    pk_we = 0;
    clean(1); fire(0, "R12 next cycle sees new");
    wkey(3, 1, 24'h123456, 3'b010);
    clean(2); fire(0, "R12 lowest index wins");
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R1 all results seen", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule